// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the two-wire PHY management bus. It generates the management clock (MDC) and serialises complete Clause 22 read and write frames onto the bidirectional data line (MDIO). One write to the command word starts a transaction. That word carries a start flag, the operation, the PHY address, the register address and, for writes, the 16-bit payload.

While a frame is on the wire, the start flag reads back as 1. The block clears the flag itself when the last bit has been sent. For reads, the 16 bits returned by the PHY are placed in the low half of a separate result word. Software polls the flag and then reads the result. The MDC half period is set by a 6-bit threshold input. Between frames, MDC rests low and MDIO is not driven.

Top module: `mdio_master`

## Requirements
- R1: After reset, both readable words (selector 0 = command, selector 1 = result) are zero, `mdc` is 0, `mdio_oe` is 0 and `mdio_o` is 1.
- R2: Command word layout: bit 31 start/busy, bit 28 Clause 22 select, bit 27 read, bit 26 write, bits 25:21 PHY address, bits 20:16 register address, bits 15:0 write payload. A valid write sends 32 ones, then 01, then 01, then the PHY address, then the register address (both MSB first), then the turnaround pattern 10, then the 16 payload bits MSB first.
- R3: A valid read sends 32 ones, then 01, then 10, then the two addresses. The master holds `mdio_oe` low for the two turnaround cycles and the 16 data cycles. It shifts the 16 data bits in MSB first and places them in result bits 15:0, with bits 31:16 read as zero.
- R4: Command bit 31 reads 1 from the cycle after a valid start until the frame ends. It then reads 0. A frame lasts 64 MDC periods, and MDC only rises while a frame is active.
- R5: The MDC period is 2*(T+1) clock cycles, where T is `mdc_thresh`.
- R6: `mdio_o` changes only together with a falling edge of MDC, and MDIO is sampled on a rising edge.
- R7: A command write while a frame is active is ignored. The stored fields and the frame on the wire are unchanged.
- R8: If start is set while the read and write bits are both 0, both 1, or bit 28 is 0, no frame is sent and bit 31 reads 0 on the next cycle.
- R9: When no frame is active, `mdc` is 0, `mdio_oe` is 0 and `mdio_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Word select: 0 command, 1 result |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word |
| mdc_thresh | input | 6 | MDC half-period threshold T |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line value |

## Verification
Two functions can fall in the same cycle. The first is a new command write. The second is the frame engine, which owns the busy flag and shift state. The bench provokes this by issuing a second command with a different PHY address in the middle of a frame. It then judges the readback fields and the full 64-bit capture taken on MDC rising edges, and both must match the first command only. A second meeting point is the final falling MDC edge, where the busy flag clears and the received word is loaded. This is judged by polling the flag and comparing the busy length and the result word against values the bench derives from the threshold and its own PHY model.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int DATA_BITS  = 16;
  localparam logic [5:0] TA_IDX   = 6'd46;
  localparam logic [5:0] DATA_IDX = 6'd48;
  localparam logic [5:0] LAST_IDX = 6'd63;

  localparam int GO_BIT = 31;
  localparam int C22_BIT = 28;
  localparam int RD_BIT = 27;
  localparam int WR_BIT = 26;

  // Assemble the full serial frame, first bit in the MSB.
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic rd, input logic [4:0] phy, input logic [4:0] rga,
    input logic [DATA_BITS-1:0] wd);
    logic [1:0] op;
    logic [1:0] ta;
    logic [DATA_BITS-1:0] pay;
    op  = rd ? 2'b10 : 2'b01;
    ta  = rd ? 2'b11 : 2'b10;
    pay = rd ? {DATA_BITS{1'b1}} : wd;
    return {32'hFFFF_FFFF, 2'b01, op, phy, rga, ta, pay};
  endfunction

  // A start request is accepted only for exactly one operation in Clause 22.
  function automatic logic cmd_ok(input logic [31:0] w);
    return w[C22_BIT] && (w[RD_BIT] ^ w[WR_BIT]);
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int THR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [THR_W-1:0] thresh,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [THR_W-1:0] cnt;
  logic term;

  assign term     = run && (cnt == thresh);
  assign rise_evt = term && !mdc;
  assign fall_evt = term && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (term) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // MDC may only rise while a frame is running
  assert_mdc_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $past(run));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 start_rd,
  input  logic [4:0]           start_phy,
  input  logic [4:0]           start_reg,
  input  logic [DATA_BITS-1:0] start_wd,
  input  logic                 rise_evt,
  input  logic                 fall_evt,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 done,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic [DATA_BITS-1:0] rx_data
);
  logic [FRAME_BITS-1:0] sh;
  logic [FRAME_BITS-1:0] frm_new;
  logic [5:0] idx;
  logic is_rd;

  assign frm_new = build_frame(start_rd, start_phy, start_reg, start_wd);
  assign done    = busy && fall_evt && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      sh      <= '0;
      is_rd   <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rx_data <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      idx     <= '0;
      sh      <= frm_new;
      is_rd   <= start_rd;
      mdio_o  <= frm_new[FRAME_BITS-1];
      mdio_oe <= 1'b1;
      rx_data <= '0;
    end else if (busy) begin
      if (rise_evt && is_rd && idx >= DATA_IDX)
        rx_data <= {rx_data[DATA_BITS-2:0], mdio_i};
      if (fall_evt) begin
        if (idx == LAST_IDX) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          idx     <= idx + 1'b1;
          sh      <= {sh[FRAME_BITS-2:0], 1'b0};
          mdio_o  <= sh[FRAME_BITS-2];
          mdio_oe <= !(is_rd && idx >= TA_IDX - 6'd1);
        end
      end
    end
  end

  // Output bit may only move on a falling MDC event
  assert_mdio_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $past(fall_evt));
  // Line released during read turnaround and data
  assert_read_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_rd && idx >= TA_IDX) |-> !mdio_oe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int THR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [THR_W-1:0] mdc_thresh,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic [30:0] cmd_q;
  logic [DATA_BITS-1:0] res_q;
  logic [DATA_BITS-1:0] rx_data;
  logic cmd_wr, start, busy, done, rise_evt, fall_evt;

  assign cmd_wr = bus_wr && !bus_addr;
  assign start  = cmd_wr && !busy && bus_wdata[GO_BIT] && cmd_ok(bus_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      res_q <= '0;
    end else begin
      if (cmd_wr && !busy) cmd_q <= bus_wdata[30:0];
      if (done && cmd_q[RD_BIT]) res_q <= rx_data;
    end
  end

  assign bus_rdata = bus_addr ? {{(32-DATA_BITS){1'b0}}, res_q} : {busy, cmd_q};

  mdio_clkdiv #(.THR_W(THR_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .thresh(mdc_thresh),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt));

  mdio_frame u_frm (
    .clk(clk), .rst_n(rst_n), .start(start), .start_rd(bus_wdata[RD_BIT]),
    .start_phy(bus_wdata[25:21]), .start_reg(bus_wdata[20:16]),
    .start_wd(bus_wdata[15:0]), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .mdio_i(mdio_i), .busy(busy), .done(done), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .rx_data(rx_data));

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(cmd_q));
  assert_bad_cmd_no_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && bus_wdata[GO_BIT] && !cmd_ok(bus_wdata)) |=> !busy);
  assert_idle_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe && mdio_o));
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0] mdc_thresh = 6'd1;
  logic mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rise_cnt = 0;
  int t0 = 0, t1 = 0;
  int oe_err = 0;
  int r6_viol = 0;
  logic last_o = 1'b1;
  logic rd_mode = 1'b0;
  logic [63:0] cap = '0;
  logic [63:0] phy_frame = '1;
  logic phy_bit;

  always #2 clk = ~clk;

  mdio_master u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc_thresh(mdc_thresh),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  // PHY model: releases line except turnaround-low and data during reads
  always @* begin
    if (rd_mode && rise_cnt >= 46 && rise_cnt < 64) phy_bit = phy_frame[63 - rise_cnt];
    else phy_bit = 1'b1;
  end
  assign mdio_i = mdio_oe ? mdio_o : phy_bit;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge mdc) begin
    if (rise_cnt < 64) begin
      cap[63 - rise_cnt] = mdio_i;
      if (rd_mode && rise_cnt >= 46 && mdio_oe) oe_err++;
    end
    rise_cnt++;
    if (rise_cnt == 1) t0 = cyc;
    if (rise_cnt == 2) t1 = cyc;
  end

  always @(negedge clk) begin
    if (rst_n && mdc && (mdio_o !== last_o)) r6_viol++;
    last_o = mdio_o;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = 1'b0;
  endtask

  function automatic logic [31:0] mk_cmd(input logic rd, input logic wr,
    input logic c22, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    logic [31:0] w;
    w = 32'h0;
    w[31] = 1'b1; w[28] = c22; w[27] = rd; w[26] = wr;
    w[25:21] = phy; w[20:16] = ra; w[15:0] = d;
    return w;
  endfunction

  // Wait out a frame, returning the number of cycles the flag read 1
  task automatic wait_idle(output int n);
    n = 0;
    bus_addr = 1'b0;
    @(negedge clk);
    while (bus_rdata[31] && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    bus_addr = 1'b0; #1;
    chk("R1 cmd", bus_rdata, 0);
    bus_addr = 1'b1; #1;
    chk("R1 res", bus_rdata, 0);
    bus_addr = 1'b0;
    chk("R1 lines", {mdc, mdio_oe, mdio_o}, 3'b001);
  endtask

  task automatic t_write(input logic [5:0] thr, input logic [4:0] phy,
    input logic [4:0] ra, input logic [15:0] d);
    int n;
    logic [63:0] exp;
    mdc_thresh = thr; rd_mode = 1'b0; rise_cnt = 0;
    bus_write(1'b0, mk_cmd(1'b0, 1'b1, 1'b1, phy, ra, d));
    wait_idle(n);
    exp = {32'hFFFF_FFFF, 4'b0101, phy, ra, 2'b10, d};
    chk("R2 write frame", cap, exp);
    chk("R4 busy length", n, 128 * (thr + 1));
    chk("R4 mdc rises", rise_cnt, 64);
    chk("R5 mdc period", t1 - t0, 2 * (thr + 1));
    chk("R9 idle lines", {mdc, mdio_oe, mdio_o}, 3'b001);
  endtask

  task automatic t_read(input logic [5:0] thr, input logic [4:0] phy,
    input logic [4:0] ra, input logic [15:0] d);
    int n;
    mdc_thresh = thr; rd_mode = 1'b1; rise_cnt = 0; oe_err = 0;
    phy_frame = {48'hFFFF_FFFF_FFFE, d};
    bus_write(1'b0, mk_cmd(1'b1, 1'b0, 1'b1, phy, ra, 16'h0));
    wait_idle(n);
    chk("R3 read header", cap[63:18], {32'hFFFF_FFFF, 4'b0110, phy, ra});
    chk("R3 turnaround", cap[17:16], 2'b10);
    chk("R3 line released", oe_err, 0);
    bus_addr = 1'b1; #1;
    chk("R3 result word", bus_rdata, {16'h0, d});
    bus_addr = 1'b0;
    chk("R4 busy length read", n, 128 * (thr + 1));
    rd_mode = 1'b0;
  endtask

  task automatic t_busy_ignore;
    int n;
    logic [63:0] exp;
    mdc_thresh = 6'd2; rd_mode = 1'b0; rise_cnt = 0;
    bus_write(1'b0, mk_cmd(1'b0, 1'b1, 1'b1, 5'h0A, 5'h03, 16'hBEEF));
    repeat (40) @(posedge clk);
    bus_write(1'b0, mk_cmd(1'b1, 1'b0, 1'b1, 5'h15, 5'h1C, 16'h1234));
    bus_addr = 1'b0; @(negedge clk);
    chk("R7 fields kept", bus_rdata, mk_cmd(1'b0, 1'b1, 1'b1, 5'h0A, 5'h03, 16'hBEEF));
    wait_idle(n);
    exp = {32'hFFFF_FFFF, 4'b0101, 5'h0A, 5'h03, 2'b10, 16'hBEEF};
    chk("R7 frame intact", cap, exp);
  endtask

  task automatic t_invalid(input logic rd, input logic wr, input logic c22, input string tag);
    rise_cnt = 0;
    bus_write(1'b0, mk_cmd(rd, wr, c22, 5'h01, 5'h02, 16'h5555));
    bus_addr = 1'b0; @(negedge clk);
    chk(tag, bus_rdata[31], 1'b0);
    repeat (20) @(posedge clk);
    chk("R8 no mdc", rise_cnt, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_write(6'd1, 5'h11, 5'h0B, 16'hA5C3);
    t_write(6'd0, 5'h1F, 5'h00, 16'h0001);
    t_write(6'd4, 5'h00, 5'h1F, 16'h8000);
    t_read(6'd1, 5'h05, 5'h02, 16'h7E81);
    t_read(6'd3, 5'h1A, 5'h11, 16'hC003);
    t_busy_ignore;
    t_invalid(1'b0, 1'b0, 1'b1, "R8 neither op");
    t_invalid(1'b1, 1'b1, 1'b1, "R8 both ops");
    t_invalid(1'b0, 1'b1, 1'b0, "R8 clause bit clear");
    chk("R6 mdio moved while mdc high", r6_viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule